// File: doc/BRIEF.md
# Victim Cache with Sequential Stream Prefetch

This block sits beside a direct-mapped primary cache, between it and the next memory level. It holds two small structures. The first is a fully associative victim store that only ever receives lines the primary cache throws out. The second is a stream buffer of sequentially prefetched lines. When the primary cache misses, it presents the missing line address on the lookup port. If the miss displaced a line, that line is presented on the eviction port in the same cycle. The block answers from the victim store first and from the stream buffer head second. Only when both miss does it fetch the line from the next level.

Every lookup that misses both structures flushes the stream buffer. The buffer then restarts prefetching at the line after the miss and keeps itself topped up, one next-level request at a time, whenever no lookup needs the port. A lookup that hits the stream buffer head pops that line and frees a slot, so the next sequential line is fetched. A victim hit swaps lines: the displaced primary line takes the entry that was hit. Evictions that come without a hitting lookup are placed in the victim store in insertion order, and the oldest insertion is overwritten first.

Only one next-level transaction is ever outstanding. While it is in flight, `lk_ready` is low. Lines are identified by line address; data travels as one word per line.

Top module: `vcsp_top`

## Requirements
- R1: After reset the block makes no response and no next-level request, and holds `lk_ready` high. No prefetch starts until the first lookup that misses both structures.
- R2: A line written through the eviction port, when looked up later, is answered from the victim store with `rsp_src` = 1 on the cycle after acceptance, carrying the evicted data, and no next-level request is made for it.
- R3: On a victim hit with `ev_valid` high in the same cycle, the evicted line is stored in the entry that was hit. On a victim hit without an eviction, that entry is freed, so a repeat lookup of the same line misses.
- R4: An eviction that does not swap is written over the least recently inserted slot in rotation. After `VDEPTH`+1 such evictions of distinct lines, the first of them is gone and the others remain.
- R5: A lookup that misses both structures issues one next-level request for exactly that line address. The returned data is then given back with `rsp_src` = 3 on the cycle after `nl_rsp_valid`.
- R6: After such a miss, the block prefetches lines miss+1, miss+2, … in increasing order until `SDEPTH` lines are buffered. It issues one request at a time, and only while no lookup is being served.
- R7: A lookup matching the stream buffer head (its oldest buffered line) is answered on the next cycle with `rsp_src` = 2 and the prefetched data. That entry is popped, and the next sequential line after the last one buffered is then requested.
- R8: A lookup that matches a buffered line other than the head is treated as a miss. The buffer is flushed and prefetch restarts at that line + 1.
- R9: When a line is present in both structures, the victim store answers, and the stream buffer is left unchanged.
- R10: `nl_req_valid` and `nl_req_addr` hold steady until `nl_req_ready` is seen. `lk_ready` stays low from the time a next-level request is raised until its response returns.
- R11: `rsp_valid` is never high in the same cycle as `nl_req_valid`. Whenever it is high, `rsp_src` is nonzero (1 victim, 2 stream, 3 next level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Primary miss lookup request |
| lk_ready | output | 1 | Lookup accepted this cycle when high |
| lk_addr | input | AW | Line address that missed in the primary cache |
| ev_valid | input | 1 | Primary cache evicts a line this cycle |
| ev_addr | input | AW | Line address of the evicted line |
| ev_data | input | DW | Data of the evicted line |
| rsp_valid | output | 1 | One-cycle response to an accepted lookup |
| rsp_src | output | 2 | Source of the response: 1 victim, 2 stream, 3 next level |
| rsp_data | output | DW | Line data for the response |
| nl_req_valid | output | 1 | Next-level read request |
| nl_req_ready | input | 1 | Next level accepts the request |
| nl_req_addr | output | AW | Line address requested from the next level |
| nl_rsp_valid | input | 1 | Next level returns data for the outstanding request |
| nl_rsp_data | input | DW | Returned line data |

## Verification
The assertions take for granted that `nl_rsp_valid` pulses exactly once per accepted request and never while nothing is outstanding. They also assume that the line on the eviction port is not already held in the victim store, and that `lk_valid` is raised for a single cycle. The bench keeps within these assumptions. Its next-level model answers each handshake once after a fixed latency. It drives a lookup only at a falling edge where `lk_ready` was already seen high, and it drops the lookup after one cycle. Every evicted address is chosen so that it is not present in the victim store at that moment.

// File: rtl/vcsp_pkg.sv
package vcsp_pkg;
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_VICTIM = 2'd1,
        SRC_STREAM = 2'd2,
        SRC_NEXT   = 2'd3
    } rsp_src_e;

    typedef enum logic [1:0] {
        NL_IDLE = 2'd0,
        NL_REQ  = 2'd1,
        NL_WAIT = 2'd2
    } nl_state_e;
endpackage

// File: rtl/vcsp_victim.sv
module vcsp_victim #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] lk_addr,
    input  logic          ev_valid,
    input  logic [AW-1:0] ev_addr,
    input  logic [DW-1:0] ev_data,
    output logic          hit,
    output logic [DW-1:0] hit_data
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] tag;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [DEPTH-1:0]         vld;
        logic [PW-1:0]            ptr;
    } vs_t;

    vs_t q, d;
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    hit_idx;

    // fully associative compare, one comparator per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = q.vld[g] && (q.tag[g] == lk_addr);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = PW'(i);
        end
    end

    assign hit      = |match;
    assign hit_data = q.data[hit_idx];

    always_comb begin
        d = q;
        if (take && hit) begin
            // swap: the displaced primary line takes the hit slot
            if (ev_valid) begin
                d.tag[hit_idx]  = ev_addr;
                d.data[hit_idx] = ev_data;
            end else begin
                d.vld[hit_idx] = 1'b0;
            end
        end else if (ev_valid) begin
            d.tag[q.ptr]  = ev_addr;
            d.data[q.ptr] = ev_data;
            d.vld[q.ptr]  = 1'b1;
            d.ptr = (q.ptr == PW'(DEPTH - 1)) ? '0 : q.ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/vcsp_stream.sv
module vcsp_stream #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    input  logic          flush,
    input  logic [AW-1:0] flush_base,
    input  logic          pop,
    input  logic          fill,
    input  logic [DW-1:0] fill_data,
    output logic          head_hit,
    output logic [DW-1:0] head_data,
    output logic          can_fetch,
    output logic [AW-1:0] fetch_addr
);
    // DEPTH must be a power of two: ring indices wrap naturally
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] data;
        logic [IW-1:0]            head;
        logic [CW-1:0]            cnt;
        logic [AW-1:0]            next;
        logic                     active;
    } sb_t;

    sb_t q, d;
    logic [AW-1:0] head_addr;
    logic [IW-1:0] tail;

    // buffered lines are next-cnt .. next-1, oldest at head
    assign head_addr  = q.next - AW'(q.cnt);
    assign tail       = q.head + IW'(q.cnt);
    assign head_hit   = (q.cnt != '0) && (head_addr == lk_addr);
    assign head_data  = q.data[q.head];
    assign can_fetch  = q.active && (q.cnt < CW'(DEPTH));
    assign fetch_addr = q.next;

    always_comb begin
        d = q;
        if (flush) begin
            d.cnt    = '0;
            d.head   = '0;
            d.next   = flush_base;
            d.active = 1'b1;
        end else begin
            if (pop) d.head = q.head + IW'(1);
            if (fill) begin
                d.data[tail] = fill_data;
                d.next       = q.next + AW'(1);
            end
            d.cnt = q.cnt + CW'(fill) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/vcsp_top.sv
module vcsp_top
    import vcsp_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int VDEPTH = 4,
    parameter int SDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_valid,
    output logic          lk_ready,
    input  logic [AW-1:0] lk_addr,
    input  logic          ev_valid,
    input  logic [AW-1:0] ev_addr,
    input  logic [DW-1:0] ev_data,
    output logic          rsp_valid,
    output logic [1:0]    rsp_src,
    output logic [DW-1:0] rsp_data,
    output logic          nl_req_valid,
    input  logic          nl_req_ready,
    output logic [AW-1:0] nl_req_addr,
    input  logic          nl_rsp_valid,
    input  logic [DW-1:0] nl_rsp_data
);
    typedef struct packed {
        nl_state_e     state;
        logic [AW-1:0] req_addr;
        logic          demand;
        logic          rsp_valid;
        rsp_src_e      rsp_src;
        logic [DW-1:0] rsp_data;
    } ctl_t;

    ctl_t q, d;

    logic          take;
    logic          v_hit, s_hit, s_can;
    logic [DW-1:0] v_data, s_data;
    logic [AW-1:0] s_fetch;
    logic          s_flush, s_pop, s_fill;

    assign take = lk_valid && (q.state == NL_IDLE);

    vcsp_victim #(.AW(AW), .DW(DW), .DEPTH(VDEPTH)) victim_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .lk_addr  (lk_addr),
        .ev_valid (ev_valid),
        .ev_addr  (ev_addr),
        .ev_data  (ev_data),
        .hit      (v_hit),
        .hit_data (v_data)
    );

    vcsp_stream #(.AW(AW), .DW(DW), .DEPTH(SDEPTH)) stream_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr    (lk_addr),
        .flush      (s_flush),
        .flush_base (lk_addr + AW'(1)),
        .pop        (s_pop),
        .fill       (s_fill),
        .fill_data  (nl_rsp_data),
        .head_hit   (s_hit),
        .head_data  (s_data),
        .can_fetch  (s_can),
        .fetch_addr (s_fetch)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_src   = SRC_NONE;
        s_flush     = 1'b0;
        s_pop       = 1'b0;
        s_fill      = 1'b0;
        unique case (q.state)
            NL_IDLE: begin
                if (lk_valid) begin
                    if (v_hit) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_src   = SRC_VICTIM;
                        d.rsp_data  = v_data;
                    end else if (s_hit) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_src   = SRC_STREAM;
                        d.rsp_data  = s_data;
                        s_pop       = 1'b1;
                    end else begin
                        s_flush    = 1'b1;
                        d.req_addr = lk_addr;
                        d.demand   = 1'b1;
                        d.state    = NL_REQ;
                    end
                end else if (s_can) begin
                    d.req_addr = s_fetch;
                    d.demand   = 1'b0;
                    d.state    = NL_REQ;
                end
            end
            NL_REQ: begin
                if (nl_req_ready) d.state = NL_WAIT;
            end
            NL_WAIT: begin
                if (nl_rsp_valid) begin
                    if (q.demand) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_src   = SRC_NEXT;
                        d.rsp_data  = nl_rsp_data;
                    end else begin
                        s_fill = 1'b1;
                    end
                    d.state = NL_IDLE;
                end
            end
            default: d.state = NL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lk_ready     = (q.state == NL_IDLE);
    assign nl_req_valid = (q.state == NL_REQ);
    assign nl_req_addr  = q.req_addr;
    assign rsp_valid    = q.rsp_valid;
    assign rsp_src      = q.rsp_src;
    assign rsp_data     = q.rsp_data;
endmodule

// File: rtl/vcsp_chk.sv
module vcsp_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic          lk_ready,
    input logic [AW-1:0] lk_addr,
    input logic          rsp_valid,
    input logic [1:0]    rsp_src,
    input logic          nl_req_valid,
    input logic          nl_req_ready,
    input logic [AW-1:0] nl_req_addr
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nl_req_valid && !nl_req_ready |=> nl_req_valid && $stable(nl_req_addr));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nl_req_valid |-> !lk_ready);

    // R5
    accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready |=> rsp_valid || nl_req_valid);

    // R5
    demand_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_valid && lk_ready) && nl_req_valid |-> nl_req_addr == $past(lk_addr));

    // R11
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_src != 2'd0);

    // R11
    rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && nl_req_valid));
endmodule

bind vcsp_top vcsp_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_ready     (lk_ready),
    .lk_addr      (lk_addr),
    .rsp_valid    (rsp_valid),
    .rsp_src      (rsp_src),
    .nl_req_valid (nl_req_valid),
    .nl_req_ready (nl_req_ready),
    .nl_req_addr  (nl_req_addr)
);

// File: tb/vcsp_top_tb_top.sv
`timescale 1ns/1ps
module vcsp_top_tb_top;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic          lk_ready;
    logic [AW-1:0] lk_addr = '0;
    logic          ev_valid = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [DW-1:0] ev_data = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_src;
    logic [DW-1:0] rsp_data;
    logic          nl_req_valid;
    logic          nl_req_ready;
    logic [AW-1:0] nl_req_addr;
    logic          nl_rsp_valid = 1'b0;
    logic [DW-1:0] nl_rsp_data = '0;

    logic          stall = 1'b0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    vcsp_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
        .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_data(rsp_data),
        .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready),
        .nl_req_addr(nl_req_addr),
        .nl_rsp_valid(nl_rsp_valid), .nl_rsp_data(nl_rsp_data)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    // next-level model: fixed latency, logs every accepted request
    assign nl_req_ready = !stall;
    logic [AW-1:0] req_log [64];
    int            req_n = 0;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_addr = '0;
    int            lat_cnt = 0;

    always @(posedge clk) begin
        nl_rsp_valid <= 1'b0;
        if (rst_n) begin
            if (nl_req_valid && nl_req_ready) begin
                pend             <= 1'b1;
                pend_addr        <= nl_req_addr;
                lat_cnt          <= LAT;
                req_log[req_n % 64] <= nl_req_addr;
                req_n            <= req_n + 1;
            end else if (pend) begin
                if (lat_cnt == 1) begin
                    nl_rsp_valid <= 1'b1;
                    nl_rsp_data  <= mem_word(pend_addr);
                    pend         <= 1'b0;
                end else begin
                    lat_cnt <= lat_cnt - 1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic evv,
                         input logic [AW-1:0] ea, input logic [DW-1:0] ed);
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        ev_valid = evv;  ev_addr = ea; ev_data = ed;
        @(negedge clk);
        lk_valid = 1'b0; ev_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [1:0] src, output logic [DW-1:0] dat, output int lat);
        lat = 0;
        while (!rsp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        src = rsp_valid ? rsp_src : 2'd0;
        dat = rsp_data;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic evv,
                          input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                          output logic [1:0] src, output logic [DW-1:0] dat, output int lat);
        issue(a, evv, ea, ed);
        wait_rsp(src, dat, lat);
    endtask

    task automatic evict(input logic [AW-1:0] a, input logic [DW-1:0] dt);
        @(negedge clk);
        ev_valid = 1'b1; ev_addr = a; ev_data = dt;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
            check("R1 no prefetch before first miss", 32'(nl_req_valid), 32'd0);
            check("R1 lk_ready", 32'(lk_ready), 32'd1);
        end
    endtask

    task automatic t_cold_miss();
        logic [1:0] s; logic [DW-1:0] dt; int l; int r0;
        r0 = req_n;
        lookup(16'h0100, 1'b0, '0, '0, s, dt, l);
        check("R5 miss source", 32'(s), 32'd3);
        check("R5 miss data", dt, mem_word(16'h0100));
        settle(60);
        check("R6 request count", 32'(req_n - r0), 32'd5);
        check("R5 demand address", 32'(req_log[r0 % 64]), 32'h0100);
        for (int k = 1; k <= 4; k++)
            check("R6 sequential prefetch", 32'(req_log[(r0 + k) % 64]), 32'(16'h0100 + k));
    endtask

    task automatic t_stream_hit();
        logic [1:0] s; logic [DW-1:0] dt; int l; int r0;
        r0 = req_n;
        lookup(16'h0101, 1'b0, '0, '0, s, dt, l);
        check("R7 head hit source", 32'(s), 32'd2);
        check("R7 head hit data", dt, mem_word(16'h0101));
        check("R7 head hit latency", 32'(l), 32'd0);
        settle(40);
        check("R7 one refill", 32'(req_n - r0), 32'd1);
        check("R7 refill address", 32'(req_log[r0 % 64]), 32'h0105);
    endtask

    task automatic t_non_head();
        logic [1:0] s; logic [DW-1:0] dt; int l; int r0;
        r0 = req_n;
        lookup(16'h0104, 1'b0, '0, '0, s, dt, l); // head is 0x0102
        check("R8 non-head is miss", 32'(s), 32'd3);
        settle(60);
        check("R8 request count", 32'(req_n - r0), 32'd5);
        check("R8 restart address", 32'(req_log[(r0 + 1) % 64]), 32'h0105);
        check("R8 restart last", 32'(req_log[(r0 + 4) % 64]), 32'h0108);
    endtask

    task automatic t_priority();
        logic [1:0] s; logic [DW-1:0] dt; int l;
        evict(16'h0105, 32'hD3D3_0105);
        lookup(16'h0105, 1'b0, '0, '0, s, dt, l);
        check("R9 victim wins", 32'(s), 32'd1);
        check("R9 victim data", dt, 32'hD3D3_0105);
        lookup(16'h0105, 1'b0, '0, '0, s, dt, l);
        check("R9 stream head untouched", 32'(s), 32'd2);
        check("R9 stream data", dt, mem_word(16'h0105));
        settle(40);
    endtask

    task automatic t_swap();
        logic [1:0] s; logic [DW-1:0] dt; int l; int r0;
        evict(16'h0200, 32'hD1D1_0200);
        r0 = req_n;
        lookup(16'h0200, 1'b1, 16'h0300, 32'hD2D2_0300, s, dt, l);
        check("R2 victim source", 32'(s), 32'd1);
        check("R2 victim data", dt, 32'hD1D1_0200);
        check("R2 one-cycle answer", 32'(l), 32'd0);
        lookup(16'h0300, 1'b0, '0, '0, s, dt, l);
        check("R3 swapped line source", 32'(s), 32'd1);
        check("R3 swapped line data", dt, 32'hD2D2_0300);
        check("R2 no next-level access", 32'(req_n - r0), 32'd0);
        lookup(16'h0300, 1'b0, '0, '0, s, dt, l);
        check("R3 freed entry misses", 32'(s), 32'd3);
        settle(60);
    endtask

    task automatic t_fifo();
        logic [1:0] s; logic [DW-1:0] dt; int l;
        for (int k = 0; k < 5; k++)
            evict(16'h0500 + 16'(k), 32'hE000_0500 + k);
        lookup(16'h0500, 1'b0, '0, '0, s, dt, l);
        check("R4 oldest replaced", 32'(s), 32'd3);
        lookup(16'h0501, 1'b0, '0, '0, s, dt, l);
        check("R4 second kept", 32'(s), 32'd1);
        check("R4 second data", dt, 32'hE000_0501);
        lookup(16'h0504, 1'b0, '0, '0, s, dt, l);
        check("R4 newest kept", 32'(s), 32'd1);
        settle(60);
    endtask

    task automatic t_backpressure();
        logic [1:0] s; logic [DW-1:0] dt; int l;
        stall = 1'b1;
        issue(16'h0700, 1'b0, '0, '0);
        for (int i = 0; i < 4; i++) begin
            check("R10 request held", 32'(nl_req_valid), 32'd1);
            check("R10 address held", 32'(nl_req_addr), 32'h0700);
            check("R10 lookups blocked", 32'(lk_ready), 32'd0);
            check("R11 no response while requesting", 32'(rsp_valid), 32'd0);
            @(negedge clk);
        end
        stall = 1'b0;
        wait_rsp(s, dt, l);
        check("R5 stalled miss source", 32'(s), 32'd3);
        check("R5 stalled miss data", dt, mem_word(16'h0700));
        @(negedge clk);
        check("R11 response one cycle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_miss();
        t_stream_hit();
        t_non_head();
        t_priority();
        t_swap();
        t_fifo();
        t_backpressure();
        finish_run();
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule